// File: doc/BRIEF.md
# Cache allocation class-of-service mask selector

This block keeps the cache allocation settings of a small multi-thread core. Each hardware thread has an association register. That register names the class of service the thread currently runs under, together with a monitoring identifier. A bank of capacity bitmask registers holds one way-mask per slot. A single configuration register carries an enable bit that switches the bank into split code/data mode.

Software reaches all of these registers through a simple register port. The port accepts writes and registered reads, and it reports a one-cycle fault for any illegal write.

The cache side uses a lookup port. It presents a thread index and whether the access is a code fetch or a data access. One cycle later the block returns the capacity mask that governs that access. In plain mode a class selects its own slot for both kinds of access. In split mode the bank is read as pairs: one data slot and one code slot per class. This halves the number of usable classes. A class beyond the active limit gets an unrestricted mask and a flag.

Top module: `cat_mask_sel`

## Requirements
- R1: After reset every thread is in class 0, every mask slot holds all ones and the configuration register reads 0. Every lookup therefore returns an all-ones mask with the out-of-range flag low.
- R2: The association register sits at address 0xC8F, and `cfg_thread` picks which thread's copy is addressed. The class field is bits [63:32] and the monitoring ID is bits [MON_W-1:0] (bits [9:0] by default). One write replaces both fields, and all other bits read as zero.
- R3: The configuration register sits at address 0xC81, and bit 0 is the split code/data enable. A write with any of bits [63:1] set raises `cfg_fault` in the next cycle and leaves the register unchanged. On reads, bits [63:1] are zero.
- R4: Mask slot i sits at address MASK_BASE+i (0xC90 to 0xC9F by default) and holds bits [MASK_W-1:0]. A write with any bit at or above MASK_W set faults and leaves the slot unchanged.
- R5: A write to an address that maps to no register raises `cfg_fault` in the next cycle and changes no register. A legal write never raises `cfg_fault`.
- R6: In plain mode (enable = 0), class n selects slot n for both code and data lookups.
- R7: In split mode (enable = 1), class n selects slot 2n for data lookups (`lk_is_code` = 0) and slot 2n+1 for code lookups (`lk_is_code` = 1).
- R8: The highest usable class is NUM_MASKS-1 in plain mode and (NUM_MASKS-1)>>1 in split mode. A lookup whose class exceeds the active limit returns all ones with `lk_oor` = 1.
- R9: The lookup result is registered. `lk_rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and `lk_mask`/`lk_oor` are valid in that cycle.
- R10: A read (`cfg_rd_en`) presents the register contents on `cfg_rdata` in the next cycle. A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_thread | input | TH_W | Thread whose association register is addressed |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, one cycle after the read strobe |
| cfg_fault | output | 1 | One-cycle pulse after an illegal write |
| lk_valid | input | 1 | Lookup request |
| lk_thread | input | TH_W | Thread issuing the access |
| lk_is_code | input | 1 | 1 = code fetch, 0 = data access |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_mask | output | MASK_W | Capacity mask for the access |
| lk_oor | output | 1 | Class exceeded the active limit |

## Verification
Lookups are tried in plain and split mode with classes at zero, at each mode's limit and one past it. Each mask slot holds a distinct value, so this run separates an off-by-one limit from a wrong slot pairing. Code and data lookups on the same class in split mode distinguish the even/odd pairing from plain indexing. Config writes with single high reserved bits, over-wide mask data and addresses just outside the mapped ranges separate the fault cases from the commits. A random mix of writes, read-backs and lookups against a bench model covers interleavings such as toggling the mode while threads keep their class.

// File: rtl/cat_pkg.sv
package cat_pkg;

  localparam int unsigned ADDR_CFG   = 32'hC81;
  localparam int unsigned ADDR_ASSOC = 32'hC8F;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_ASSOC = 2'd2,
    SEL_MASK  = 2'd3
  } cfg_sel_e;

  // Highest class usable in the current mode.
  function automatic logic [31:0] cos_limit(input int unsigned n_masks, input logic split);
    logic [31:0] top;
    top = n_masks - 1;
    return split ? (top >> 1) : top;
  endfunction

endpackage

// File: rtl/cat_assoc_bank.sv
module cat_assoc_bank #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned MON_W       = 10,
  parameter int unsigned TH_W        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [TH_W-1:0] wr_thread,
  input  logic [31:0]     wr_cos,
  input  logic [MON_W-1:0] wr_mon,
  input  logic [TH_W-1:0] rd_thread,
  output logic [63:0]     rd_word,
  input  logic [TH_W-1:0] lk_thread,
  output logic [31:0]     lk_cos
);

  logic [31:0]      cos_q [NUM_THREADS];
  logic [MON_W-1:0] mon_q [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cos_q[t] <= '0;
        mon_q[t] <= '0;
      end else if (we && wr_thread == TH_W'(t)) begin
        cos_q[t] <= wr_cos;
        mon_q[t] <= wr_mon;
      end
    end
  end

  assign rd_word = {cos_q[rd_thread], {(32-MON_W){1'b0}}, mon_q[rd_thread]};
  assign lk_cos  = cos_q[lk_thread];

endmodule

// File: rtl/cat_mask_bank.sv
module cat_mask_bank #(
  parameter int unsigned NUM_MASKS = 16,
  parameter int unsigned MASK_W    = 20,
  parameter int unsigned MI_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MI_W-1:0]   widx,
  input  logic [MASK_W-1:0] wdata,
  input  logic [MI_W-1:0]   ridx,
  output logic [MASK_W-1:0] rdata,
  input  logic [MI_W-1:0]   lidx,
  output logic [MASK_W-1:0] ldata
);

  logic [MASK_W-1:0] slot_q [NUM_MASKS];

  for (genvar i = 0; i < NUM_MASKS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                        slot_q[i] <= '1;
      else if (we && widx == MI_W'(i))   slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[ridx];
  assign ldata = slot_q[lidx];

endmodule

// File: rtl/cat_mask_lookup.sv
module cat_mask_lookup
  import cat_pkg::*;
#(
  parameter int unsigned NUM_MASKS = 16,
  parameter int unsigned MASK_W    = 20,
  parameter int unsigned MI_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              split,
  input  logic [31:0]       cos,
  input  logic              is_code,
  output logic [MI_W-1:0]   slot_idx,
  output logic              in_range,
  input  logic [MASK_W-1:0] slot_mask,
  output logic              rsp_valid,
  output logic [MASK_W-1:0] mask,
  output logic              oor
);

  // Plain: class itself. Split: even slot for data, odd for code.
  function automatic logic [MI_W-1:0] slot_of(input logic [31:0] c, input logic sp, input logic code);
    logic [MI_W-1:0] plain_i;
    logic [MI_W-1:0] pair_i;
    plain_i = c[MI_W-1:0];
    pair_i  = {c[MI_W-2:0], code};
    return sp ? pair_i : plain_i;
  endfunction

  assign in_range = (cos <= cos_limit(NUM_MASKS, split));
  assign slot_idx = slot_of(cos, split, is_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      mask      <= '1;
      oor       <= 1'b0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        mask <= in_range ? slot_mask : '1;
        oor  <= !in_range;
      end
    end
  end

endmodule

// File: rtl/cat_mask_sel.sv
module cat_mask_sel
  import cat_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_MASKS   = 16,
  parameter int unsigned MASK_W      = 20,
  parameter int unsigned MON_W       = 10,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned MASK_BASE   = 32'hC90,
  localparam int unsigned TH_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned MI_W = (NUM_MASKS > 2) ? $clog2(NUM_MASKS) : 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TH_W-1:0]   cfg_thread,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  output logic              cfg_fault,
  input  logic              lk_valid,
  input  logic [TH_W-1:0]   lk_thread,
  input  logic              lk_is_code,
  output logic              lk_rsp_valid,
  output logic [MASK_W-1:0] lk_mask,
  output logic              lk_oor
);

  cfg_sel_e    sel;
  logic [31:0] addr_w;
  logic [31:0] mask_off;
  logic [MI_W-1:0] mask_idx;
  logic        bad_cfg, bad_mask, wr_fault_now;
  logic        cfg_we, assoc_we, mask_we;
  logic        split_en;
  logic [63:0] assoc_rd;
  logic [MASK_W-1:0] mask_rd;
  logic [31:0] lk_cos;
  logic [MI_W-1:0] slot_idx;
  logic        in_range;
  logic [MASK_W-1:0] slot_mask;

  assign addr_w   = 32'(cfg_addr);
  assign mask_off = addr_w - MASK_BASE;
  assign mask_idx = mask_off[MI_W-1:0];

  always_comb begin
    if (addr_w == ADDR_CFG)                      sel = SEL_CFG;
    else if (addr_w == ADDR_ASSOC)               sel = SEL_ASSOC;
    else if (mask_off < NUM_MASKS)               sel = SEL_MASK;
    else                                         sel = SEL_NONE;
  end

  assign bad_cfg  = (sel == SEL_CFG)  && (|cfg_wdata[63:1]);
  assign bad_mask = (sel == SEL_MASK) && (|cfg_wdata[63:MASK_W]);
  assign wr_fault_now = cfg_wr_en && (bad_cfg || bad_mask || sel == SEL_NONE);

  assign cfg_we   = cfg_wr_en && sel == SEL_CFG  && !bad_cfg;
  assign assoc_we = cfg_wr_en && sel == SEL_ASSOC;
  assign mask_we  = cfg_wr_en && sel == SEL_MASK && !bad_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_en  <= 1'b0;
      cfg_fault <= 1'b0;
    end else begin
      cfg_fault <= wr_fault_now;
      if (cfg_we) split_en <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
    end else if (cfg_rd_en) begin
      case (sel)
        SEL_CFG:   cfg_rdata <= {63'd0, split_en};
        SEL_ASSOC: cfg_rdata <= assoc_rd;
        SEL_MASK:  cfg_rdata <= {{(64-MASK_W){1'b0}}, mask_rd};
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  cat_assoc_bank #(
    .NUM_THREADS(NUM_THREADS), .MON_W(MON_W), .TH_W(TH_W)
  ) assoc_i (
    .clk(clk), .rst_n(rst_n),
    .we(assoc_we), .wr_thread(cfg_thread),
    .wr_cos(cfg_wdata[63:32]), .wr_mon(cfg_wdata[MON_W-1:0]),
    .rd_thread(cfg_thread), .rd_word(assoc_rd),
    .lk_thread(lk_thread), .lk_cos(lk_cos)
  );

  cat_mask_bank #(
    .NUM_MASKS(NUM_MASKS), .MASK_W(MASK_W), .MI_W(MI_W)
  ) masks_i (
    .clk(clk), .rst_n(rst_n),
    .we(mask_we), .widx(mask_idx), .wdata(cfg_wdata[MASK_W-1:0]),
    .ridx(mask_idx), .rdata(mask_rd),
    .lidx(slot_idx), .ldata(slot_mask)
  );

  cat_mask_lookup #(
    .NUM_MASKS(NUM_MASKS), .MASK_W(MASK_W), .MI_W(MI_W)
  ) lookup_i (
    .clk(clk), .rst_n(rst_n),
    .req(lk_valid), .split(split_en), .cos(lk_cos), .is_code(lk_is_code),
    .slot_idx(slot_idx), .in_range(in_range), .slot_mask(slot_mask),
    .rsp_valid(lk_rsp_valid), .mask(lk_mask), .oor(lk_oor)
  );

endmodule

// File: rtl/cat_mask_sel_chk.sv
module cat_mask_sel_chk
  import cat_pkg::*;
#(
  parameter int unsigned NUM_MASKS = 16,
  parameter int unsigned MASK_W    = 20,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MASK_BASE = 32'hC90,
  parameter int unsigned MI_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [63:0]       cfg_wdata,
  input logic              cfg_fault,
  input logic              split_en,
  input logic              lk_valid,
  input logic              lk_is_code,
  input logic              lk_rsp_valid,
  input logic [MASK_W-1:0] lk_mask,
  input logic              lk_oor,
  input logic [MI_W-1:0]   slot_idx,
  input logic              in_range
);

  logic hits_any;
  assign hits_any = (32'(cfg_addr) == ADDR_CFG) || (32'(cfg_addr) == ADDR_ASSOC) ||
                    (32'(cfg_addr) >= MASK_BASE && 32'(cfg_addr) < MASK_BASE + NUM_MASKS);

  // R3
  cfg_resv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && 32'(cfg_addr) == ADDR_CFG && (|cfg_wdata[63:1]) |=> cfg_fault && $stable(split_en));

  // R5
  unmapped_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && !hits_any |=> cfg_fault);

  // R5
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> !cfg_fault);

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rsp_valid);

  // R8
  oor_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && lk_oor |-> &lk_mask);

  // R7
  split_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && split_en && in_range |-> slot_idx[0] == lk_is_code);

endmodule

bind cat_mask_sel cat_mask_sel_chk #(
  .NUM_MASKS(NUM_MASKS), .MASK_W(MASK_W), .ADDR_W(ADDR_W),
  .MASK_BASE(MASK_BASE), .MI_W(MI_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_fault(cfg_fault), .split_en(split_en),
  .lk_valid(lk_valid), .lk_is_code(lk_is_code), .lk_rsp_valid(lk_rsp_valid),
  .lk_mask(lk_mask), .lk_oor(lk_oor),
  .slot_idx(slot_idx), .in_range(in_range)
);

// File: tb/cat_mask_sel_tb_top.sv
module cat_mask_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int NM = 16;
  localparam int MW = 20;
  localparam int MONW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [1:0]  cfg_thread = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_fault;
  logic        lk_valid = 1'b0;
  logic [1:0]  lk_thread = '0;
  logic        lk_is_code = 1'b0;
  logic        lk_rsp_valid;
  logic [MW-1:0] lk_mask;
  logic        lk_oor;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0]   m_cos [NT];
  logic [MONW-1:0] m_mon [NT];
  logic [MW-1:0] m_mask [NM];
  logic          m_split;

  always #(CLK_PERIOD/2) clk = ~clk;

  cat_mask_sel dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_thread(cfg_thread), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_fault(cfg_fault),
    .lk_valid(lk_valid), .lk_thread(lk_thread), .lk_is_code(lk_is_code),
    .lk_rsp_valid(lk_rsp_valid), .lk_mask(lk_mask), .lk_oor(lk_oor)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the write rules.
  function automatic bit exp_fault(input int addr, input logic [63:0] d);
    if (addr == 'hC81) return (d >> 1) != 0;
    if (addr == 'hC8F) return 0;
    if (addr >= 'hC90 && addr <= 'hC9F) return (d >> MW) != 0;
    return 1;
  endfunction

  function automatic logic [63:0] exp_read(input int addr, input int thr);
    if (addr == 'hC81) return {63'd0, m_split};
    if (addr == 'hC8F) return {m_cos[thr], 22'd0, m_mon[thr]};
    if (addr >= 'hC90 && addr <= 'hC9F) return {44'd0, m_mask[addr - 'hC90]};
    return 64'd0;
  endfunction

  function automatic logic [MW:0] exp_lookup(input int thr, input bit code);
    logic [31:0] c;
    c = m_cos[thr];
    if (!m_split) begin
      if (c > NM - 1) return {1'b1, {MW{1'b1}}};
      return {1'b0, m_mask[c]};
    end
    if (c > (NM - 1) / 2) return {1'b1, {MW{1'b1}}};
    return {1'b0, m_mask[c * 2 + (code ? 1 : 0)]};
  endfunction

  task automatic do_write(input int addr, input int thr, input logic [63:0] d, input string req);
    bit f;
    f = exp_fault(addr, d);
    cfg_wr_en = 1'b1; cfg_addr = 12'(addr); cfg_thread = 2'(thr); cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0;
    check(req, {63'd0, cfg_fault}, {63'd0, f});
    check("R9 idle", {63'd0, lk_rsp_valid}, 64'd0);
    if (!f) begin
      if (addr == 'hC81) m_split = d[0];
      else if (addr == 'hC8F) begin m_cos[thr] = d[63:32]; m_mon[thr] = d[MONW-1:0]; end
      else m_mask[addr - 'hC90] = d[MW-1:0];
    end
  endtask

  task automatic do_read(input int addr, input int thr, input string req);
    cfg_rd_en = 1'b1; cfg_addr = 12'(addr); cfg_thread = 2'(thr);
    @(posedge clk); @(negedge clk);
    cfg_rd_en = 1'b0;
    check(req, cfg_rdata, exp_read(addr, thr));
  endtask

  task automatic do_lookup(input int thr, input bit code, input string req);
    logic [MW:0] e;
    e = exp_lookup(thr, code);
    lk_valid = 1'b1; lk_thread = 2'(thr); lk_is_code = code;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    check("R9 valid", {63'd0, lk_rsp_valid}, 64'd1);
    check(req, {43'd0, lk_oor, lk_mask}, {43'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    for (int i = 0; i < NT; i++) begin m_cos[i] = '0; m_mon[i] = '0; end
    for (int i = 0; i < NM; i++) m_mask[i] = '1;
    m_split = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 fault", {63'd0, cfg_fault}, 64'd0);
    for (int t = 0; t < NT; t++) begin
      do_lookup(t, 0, "R1 lookup data");
      do_lookup(t, 1, "R1 lookup code");
    end
    do_read('hC81, 0, "R1 cfg read");
    do_read('hC95, 0, "R1 mask read");
    do_read('hC8F, 2, "R1 assoc read");

    // R4 distinct slot contents
    for (int i = 0; i < NM; i++) do_write('hC90 + i, 0, 64'(20'h01000 + i * 20'h111), "R4 mask write");
    for (int i = 0; i < NM; i++) do_read('hC90 + i, 0, "R4 mask read");
    do_write('hC93, 0, 64'h0010_0000, "R4 wide fault");
    do_read('hC93, 0, "R4 unchanged");

    // R2 association
    do_write('hC8F, 1, {32'd5, 32'hFFFF_F3A5}, "R2 assoc write");
    do_read('hC8F, 1, "R2 assoc read");
    do_read('hC8F, 0, "R2 other thread");

    // R6 plain mapping and R8 plain limit
    do_lookup(1, 0, "R6 plain data");
    do_lookup(1, 1, "R6 plain code");
    do_write('hC8F, 2, {32'd15, 32'd0}, "R2 write");
    do_lookup(2, 1, "R8 plain at limit");
    do_write('hC8F, 3, {32'd16, 32'd0}, "R2 write");
    do_lookup(3, 0, "R8 plain past limit");

    // R3 reserved bits
    do_write('hC81, 0, 64'h2, "R3 bit1 fault");
    do_read('hC81, 0, "R3 unchanged");
    do_write('hC81, 0, 64'h8000_0000_0000_0001, "R3 bit63 fault");
    do_read('hC81, 0, "R3 unchanged");
    do_write('hC81, 0, 64'h1, "R3 enable");
    do_read('hC81, 0, "R3 read");

    // R7 split pairs, R8 split limit
    do_lookup(1, 0, "R7 split data");
    do_lookup(1, 1, "R7 split code");
    do_write('hC8F, 2, {32'd7, 32'd0}, "R2 write");
    do_lookup(2, 1, "R8 split at limit");
    do_write('hC8F, 2, {32'd8, 32'd0}, "R2 write");
    do_lookup(2, 0, "R8 split past limit");
    do_lookup(0, 1, "R7 class0 code");

    // R5 unmapped writes, R10 unmapped reads
    do_write('hC80, 0, 64'h1, "R5 unmapped");
    do_write('hCA0, 0, 64'h1, "R5 unmapped");
    do_write('hC8E, 0, 64'h0, "R5 unmapped");
    do_read('hC81, 0, "R5 cfg intact");
    do_read('hCA0, 0, "R10 unmapped read");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      int thr;
      op = $urandom_range(0, 9);
      thr = $urandom_range(0, NT - 1);
      case (op)
        0: do_write('hC81, 0, ($urandom_range(0, 5) == 0) ? 64'(1) << $urandom_range(1, 63)
                                                         : 64'($urandom_range(0, 1)), "R3 rand");
        1, 2: do_write('hC8F, thr, {($urandom_range(0, 9) == 0) ? 32'hFFFF_0000
                                    : 32'($urandom_range(0, 17)), $urandom()}, "R2 rand");
        3: do_write('hC90 + $urandom_range(0, NM - 1), 0,
                    ($urandom_range(0, 4) == 0) ? {32'd0, $urandom()} : 64'($urandom() & 32'hFFFFF), "R4 rand");
        4: do_write($urandom_range('hC00, 'hCFF), 0, 64'($urandom()), "R5 rand");
        5: do_read($urandom_range('hC80, 'hCA2), thr, "R10 rand");
        default: do_lookup(thr, 1'($urandom_range(0, 1)), m_split ? "R7 rand" : "R6 rand");
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule